// File: doc/BRIEF.md
# Flag-Setting Integer ALU with Condition Flag Register

This block is the arithmetic and logic unit of an integer datapath. It pairs a combinational
unit with a four-bit condition flag register. The unit computes add, subtract, AND, OR or
XOR on two operands. The register holds four flags: negative (N), zero (Z), carry (C) and
overflow (V). The result appears combinationally on every cycle. The flags register on the
rising clock edge, and only when the operation may update them.

An operation may update the flags in two ways. The first is asserting `set_flags`, which
marks the current operation as flag-setting. The second is `compact_mode`: when it is high,
every operation writes the flags whatever `set_flags` says. Because the flags follow the
result directly, a flag-setting decrement that reaches zero raises Z in the same operation,
and no separate compare step is needed.

Arithmetic operations write all four flags. Logical operations write only N and Z, and C and
V keep their old values. The data width is a parameter and defaults to 32 bits. A parameter
`HAS_COMPACT` can remove the compact-mode path entirely.

Top module: `flag_alu`

## Requirements
- R1: `opcode` selects the combinational `result`: 0 gives a+b, 1 gives a-b (both modulo 2^WIDTH), 2 gives a AND b, 3 gives a OR b, 4 gives a XOR b, and codes 5 to 7 give zero.
- R2: When `set_flags` and `compact_mode` are both low, all four flags keep their previous values at the next clock edge.
- R3: When the flags are written, N takes the most significant bit of the result.
- R4: When the flags are written, Z is 1 exactly when the whole result is zero.
- R5: A flag-setting add sets C to the unsigned carry out of the top bit and V to signed overflow. For example, 0xFFFFFFFF + 1 yields 0 with N=0, Z=1, C=1, V=0.
- R6: A flag-setting subtract sets C to 1 when a >= b as unsigned values (inverted borrow). It sets V when a and b differ in sign and the result's sign differs from a. Subtracting 1 from 1 sets Z.
- R7: A flag-setting logical operation (opcodes 2 to 7) updates N and Z only, and C and V keep their previous values.
- R8: With `compact_mode` high (and `HAS_COMPACT`=1), every operation writes the flags as if `set_flags` were high.
- R9: Synchronous active-high `rst` clears all four flags to 0 at the next rising edge. Otherwise the flags take their new values at the rising edge that ends the operation's cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| opcode | input | 3 | Operation select (see R1) |
| set_flags | input | 1 | Marks the operation as flag-setting |
| compact_mode | input | 1 | Forces every operation to write the flags |
| result | output | WIDTH | Combinational result |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
Some properties are checked by assertions on every cycle:
- that the flags hold when no write is enabled;
- that C and V hold across logical operations;
- that N and Z match the previous cycle's result after a write;
- that reset clears the flags.

The exact carry and overflow values for add and subtract can only be shown by the bench's scenarios, which compare against independently computed values. The same applies to the opcode decode and to compact mode forcing a write. These scenarios are the directed wrap-around, decrement-to-zero and signed-overflow cases, and the seeded random runs.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
   typedef enum logic [2:0] {
      OPC_ADD = 3'd0,
      OPC_SUB = 3'd1,
      OPC_AND = 3'd2,
      OPC_OR  = 3'd3,
      OPC_XOR = 3'd4
   } alu_opc_e;

   localparam int FLAG_CNT = 4;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } nzcv_t;

   function automatic logic opc_is_arith(input logic [2:0] opc);
      return (opc == OPC_ADD) || (opc == OPC_SUB);
   endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             do_sub,
   output logic [WIDTH-1:0] sum,
   output logic             carry,
   output logic             ovf
);
   localparam int EXT_W = WIDTH + 1;

   logic [WIDTH-1:0] b_eff;
   logic [EXT_W-1:0] ext;

   always_comb begin
      b_eff = do_sub ? ~b : b;
      ext   = {1'b0, a} + {1'b0, b_eff} + EXT_W'(do_sub);
      sum   = ext[WIDTH-1:0];
      carry = ext[WIDTH];
      ovf   = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
   end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [2:0]       opc,
   output logic [WIDTH-1:0] res
);
   import flag_alu_pkg::*;

   always_comb begin
      unique case (opc)
         OPC_AND: res = a & b;
         OPC_OR:  res = a | b;
         OPC_XOR: res = a ^ b;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_nz,
   input  logic                wr_cv,
   input  flag_alu_pkg::nzcv_t nxt,
   output flag_alu_pkg::nzcv_t cur
);
   always_ff @(posedge clk) begin
      if (rst) begin
         cur <= '0;
      end else begin
         if (wr_nz) begin
            cur.n <= nxt.n;
            cur.z <= nxt.z;
         end
         if (wr_cv) begin
            cur.c <= nxt.c;
            cur.v <= nxt.v;
         end
      end
   end

   AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (cur == '0)); // R9
   AST_CV_HOLD: assert property (@(posedge clk) disable iff (rst)
      !wr_cv |=> $stable({cur.c, cur.v})); // R7
endmodule

// File: rtl/flag_alu.sv
module flag_alu #(
   parameter int WIDTH       = 32,
   parameter bit HAS_COMPACT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [2:0]       opcode,
   input  logic             set_flags,
   input  logic             compact_mode,
   output logic [WIDTH-1:0] result,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_c,
   output logic             flag_v
);
   import flag_alu_pkg::*;

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("flag_alu: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] arith_res, logic_res;
   logic             arith_c, arith_v, is_arith, do_wr;
   nzcv_t            nxt_flags, cur_flags;

   alu_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a(op_a), .b(op_b), .do_sub(opcode == OPC_SUB),
      .sum(arith_res), .carry(arith_c), .ovf(arith_v)
   );

   alu_logic #(.WIDTH(WIDTH)) u_logic (
      .a(op_a), .b(op_b), .opc(opcode), .res(logic_res)
   );

   if (HAS_COMPACT) begin : g_compact
      assign do_wr = set_flags | compact_mode;
   end else begin : g_plain
      assign do_wr = set_flags;
   end

   always_comb begin
      is_arith    = opc_is_arith(opcode);
      result      = is_arith ? arith_res : logic_res;
      nxt_flags.n = result[MSB];
      nxt_flags.z = (result == '0);
      nxt_flags.c = arith_c;
      nxt_flags.v = arith_v;
   end

   alu_flag_reg u_flags (
      .clk(clk), .rst(rst),
      .wr_nz(do_wr), .wr_cv(do_wr & is_arith),
      .nxt(nxt_flags), .cur(cur_flags)
   );

   assign flag_n = cur_flags.n;
   assign flag_z = cur_flags.z;
   assign flag_c = cur_flags.c;
   assign flag_v = cur_flags.v;

   AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      (!set_flags && !compact_mode) |=> $stable({flag_n, flag_z, flag_c, flag_v})); // R2
   AST_N_FROM_MSB: assert property (@(posedge clk) disable iff (rst)
      do_wr |=> (flag_n == $past(result[MSB]))); // R3
   AST_Z_FROM_RESULT: assert property (@(posedge clk) disable iff (rst)
      do_wr |=> (flag_z == ($past(result) == '0))); // R4
   AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (rst)
      !opc_is_arith(opcode) |=> $stable({flag_c, flag_v})); // R7
endmodule

// File: tb/tb_flag_alu.sv
module tb_flag_alu;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst;
   logic [W-1:0] op_a, op_b;
   logic [2:0]   opcode;
   logic         set_flags, compact_mode;
   logic [W-1:0] result;
   logic         flag_n, flag_z, flag_c, flag_v;

   int  n_run  = 0;
   int  n_fail = 0;
   logic [3:0] exp_f;

   flag_alu #(.WIDTH(W)) dut (
      .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .opcode(opcode),
      .set_flags(set_flags), .compact_mode(compact_mode), .result(result),
      .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
   );

   always #4 clk = ~clk;

   function automatic logic [W-1:0] ref_res(input logic [W-1:0] a, b, input logic [2:0] o);
      case (o)
         3'd0: return a + b;
         3'd1: return a - b;
         3'd2: return a & b;
         3'd3: return a | b;
         3'd4: return a ^ b;
         default: return '0;
      endcase
   endfunction

   function automatic logic [3:0] ref_flags(input logic [W-1:0] a, b, input logic [2:0] o,
                                            input logic [3:0] old);
      logic [W-1:0] r;
      logic c, v;
      r = ref_res(a, b, o);
      c = old[1];
      v = old[0];
      if (o == 3'd0) begin
         c = ({1'b0, a} + {1'b0, b}) > {1'b0, {W{1'b1}}};
         v = ($signed(a) < 0) == ($signed(b) < 0) && (($signed(r) < 0) != ($signed(a) < 0));
      end else if (o == 3'd1) begin
         c = (a >= b);
         v = (($signed(a) < 0) != ($signed(b) < 0)) && (($signed(r) < 0) != ($signed(a) < 0));
      end
      return {r[W-1], (r == '0), c, v};
   endfunction

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_op(input logic [W-1:0] a, b, input logic [2:0] o,
                        input logic sf, cm, input string ftag);
      @(negedge clk);
      op_a = a; op_b = b; opcode = o; set_flags = sf; compact_mode = cm;
      #1;
      check("R1 result", result, ref_res(a, b, o));
      if (sf || cm) exp_f = ref_flags(a, b, o, exp_f);
      @(posedge clk);
      #1;
      check(ftag, {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, exp_f});
   endtask

   function automatic string tag_for(input logic [2:0] o, input logic sf, cm);
      if (!sf && !cm) return "R2 flags held";
      if (!sf && cm)  return "R8 compact write";
      if (o == 3'd0)  return "R5 add flags (R3 R4)";
      if (o == 3'd1)  return "R6 sub flags (R3 R4)";
      return "R7 logic flags";
   endfunction

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd12345));
      rst = 1'b1; op_a = '0; op_b = '0; opcode = 3'd0; set_flags = 1'b0; compact_mode = 1'b0;
      exp_f = 4'b0000;
      repeat (3) @(posedge clk);
      #1;
      check("R9 reset clears", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
      @(negedge clk); rst = 1'b0;

      do_op(32'hFFFF_FFFF, 32'd1, 3'd0, 1'b1, 1'b0, "R5 wrap add Z C");
      check("R5 expected 0100+carry", {28'd0, exp_f}, 32'b0110);
      do_op(32'h7FFF_FFFF, 32'd1, 3'd0, 1'b1, 1'b0, "R5 signed ovf");
      do_op(32'd1, 32'd1, 3'd1, 1'b1, 1'b0, "R6 decrement to zero");
      check("R6 Z set", {31'd0, flag_z}, 32'd1);
      do_op(32'd0, 32'd1, 3'd1, 1'b1, 1'b0, "R6 borrow");
      do_op(32'h8000_0000, 32'd1, 3'd1, 1'b1, 1'b0, "R6 signed ovf");
      do_op(32'h8000_0000, 32'hFFFF_FFFF, 3'd2, 1'b1, 1'b0, "R7 and keeps CV, R3 N");
      do_op(32'h1234_5678, 32'h1234_5678, 3'd4, 1'b1, 1'b0, "R7 xor zero R4");
      do_op(32'hFFFF_FFFF, 32'd1, 3'd0, 1'b0, 1'b0, "R2 no write");
      do_op(32'hFFFF_FFFF, 32'd1, 3'd0, 1'b0, 1'b1, "R8 compact forces");
      do_op(32'hDEAD_BEEF, 32'h1, 3'd6, 1'b1, 1'b0, "R1 R7 unused code");

      for (int i = 0; i < 3000; i++) begin
         logic [2:0] o;
         logic sf, cm;
         logic [W-1:0] a, b;
         o  = 3'($urandom_range(0, 7));
         sf = 1'($urandom);
         cm = ($urandom_range(0, 3) == 0);
         a  = $urandom;
         b  = ($urandom_range(0, 7) == 0) ? a : $urandom;
         do_op(a, b, o, sf, cm, tag_for(o, sf, cm));
      end

      @(negedge clk); rst = 1'b1; set_flags = 1'b1;
      @(posedge clk); #1;
      exp_f = 4'b0000;
      check("R9 mid-run reset", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule